// File: doc/BRIEF.md
# Accumulator ALU with carry flag

This block is the arithmetic and logic stage of a small 8-bit processor. It holds an accumulator and a single carry/borrow flag. Each cycle with the write enable high, it combines an operand byte with the accumulator according to a 4-bit operation code, then writes the result back into the accumulator and, for arithmetic and shift operations, into the flag. Fetching the operand, stepping pointers and decoding instructions happen elsewhere. The block only gets the byte and the operation code.

Subtraction keeps the flag in inverted-borrow sense: a flag of 1 after a subtract means no borrow occurred. The borrow-including subtracts use that same sense for their incoming borrow. Logic operations never touch the flag. A zero output, taken from the stored accumulator, serves branch-on-zero logic.

Top module: `acc_alu`

## Requirements
- R1: After reset (rst_n low) the accumulator is 0, the flag is 0 and acc_zero is 1.
- R2: Codes 0 (OR), 1 (AND) and 2 (XOR) write operand OR/AND/XOR accumulator into the accumulator and leave the flag unchanged.
- R3: Code 3 (add) writes the low byte of operand + accumulator and sets the flag to the carry out (1 = carry).
- R4: Code 4 (add with carry) writes the low byte of operand + accumulator + flag and sets the flag to the carry out.
- R5: Code 5 writes operand − accumulator and code 7 writes accumulator − operand (low byte). In both cases the flag becomes 1 when no borrow occurred and 0 on a borrow.
- R6: Codes 6 and 8 are the borrow-including forms of codes 5 and 7. They subtract an extra 1 when the old flag is 0 and nothing extra when it is 1, and set the flag in the same inverted-borrow sense.
- R7: Code 9 (shift right) moves the accumulator one bit toward the LSB, fills the MSB with 0 and puts the old LSB into the flag.
- R8: Code 10 (ring shift right) behaves like code 9 but fills the MSB with the old flag.
- R9: Code 11 (shift left) moves the accumulator one bit toward the MSB, fills the LSB with 0 and puts the old MSB into the flag. Code 12 (ring shift left) does the same but fills the LSB with the old flag.
- R10: acc_zero is 1 exactly when the stored accumulator is all zeros.
- R11: With wr_en low, or with codes 13 to 15, the accumulator and flag keep their values.
- R12: Results appear on acc_q and carry_q after the rising clock edge at which wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Perform the selected operation this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| operand | input | 8 | Memory operand byte |
| acc_q | output | 8 | Accumulator |
| carry_q | output | 1 | Carry/borrow flag |
| acc_zero | output | 1 | Accumulator is zero |

## Verification
All state sits in the accumulator and the flag, and both are visible at the ports. A wrong value therefore shows on acc_q or carry_q one cycle after the operation that produced it. A wrong flag also spreads: the next add with carry, borrow-including subtract or ring shift turns it into a wrong accumulator byte. The bench chains operations so that a flag error shows up in later results as well as in its own cycle. It also checks that logic operations and unused codes leave the flag as it was.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc_q,
  output logic         carry_q,
  output logic         acc_zero
);
  logic [W:0]   sum_add, sum_md, sum_dm;
  logic         cin_add, cin_sub;
  logic [W-1:0] d_nxt;
  logic         df_nxt;

  assign cin_add = (op_sel == 4'd4) && carry_q;
  assign cin_sub = (op_sel == 4'd6 || op_sel == 4'd8) ? carry_q : 1'b1;

  assign sum_add = {1'b0, operand} + {1'b0, acc_q} + {{W{1'b0}}, cin_add};
  assign sum_md  = {1'b0, operand} + {1'b0, ~acc_q} + {{W{1'b0}}, cin_sub};
  assign sum_dm  = {1'b0, acc_q} + {1'b0, ~operand} + {{W{1'b0}}, cin_sub};

  always_comb begin
    d_nxt  = acc_q;
    df_nxt = carry_q;
    case (op_sel)
      4'd0: d_nxt = operand | acc_q;
      4'd1: d_nxt = operand & acc_q;
      4'd2: d_nxt = operand ^ acc_q;
      4'd3, 4'd4: {df_nxt, d_nxt} = sum_add;
      4'd5, 4'd6: {df_nxt, d_nxt} = sum_md;
      4'd7, 4'd8: {df_nxt, d_nxt} = sum_dm;
      4'd9:  {d_nxt, df_nxt} = {1'b0, acc_q};
      4'd10: {d_nxt, df_nxt} = {carry_q, acc_q};
      4'd11: {df_nxt, d_nxt} = {acc_q, 1'b0};
      4'd12: {df_nxt, d_nxt} = {acc_q, carry_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (wr_en) begin
      acc_q   <= d_nxt;
      carry_q <= df_nxt;
    end
  end

  assign acc_zero = ~|acc_q;
endmodule

module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [3:0]   op_sel,
  input logic [W-1:0] operand,
  input logic [W-1:0] acc_q,
  input logic         carry_q,
  input logic         acc_zero
);
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc_zero == (acc_q == '0));

  a_r2_logic_keeps_df: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sel <= 4'd2) |=> $stable(carry_q));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || op_sel >= 4'd13) |=> ($stable(acc_q) && $stable(carry_q)));

  a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sel == 4'd3) |=>
      ({carry_q, acc_q} == ($past({1'b0, operand}) + $past({1'b0, acc_q}))));

  a_r5_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sel == 4'd5) |=> (carry_q == ($past(operand) >= $past(acc_q))));

  a_r7_shr_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sel == 4'd9) |=> (!acc_q[W-1] && carry_q == $past(acc_q[0])));

  a_r9_shl_msb_out: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sel == 4'd11) |=> (!acc_q[0] && carry_q == $past(acc_q[W-1])));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_sel(op_sel),
  .operand(operand), .acc_q(acc_q), .carry_q(carry_q), .acc_zero(acc_zero)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc_q;
  logic       carry_q;
  logic       acc_zero;

  int tests = 0;
  int fails = 0;
  logic [7:0] m_d = 8'd0;
  logic       m_df = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_sel(op_sel),
    .operand(operand), .acc_q(acc_q), .carry_q(carry_q), .acc_zero(acc_zero)
  );

  task automatic model(input logic [3:0] op, input logic [7:0] m);
    logic [8:0] t;
    case (op)
      4'd0: m_d = m | m_d;
      4'd1: m_d = m & m_d;
      4'd2: m_d = m ^ m_d;
      4'd3: begin t = 9'(m) + 9'(m_d); m_d = t[7:0]; m_df = t[8]; end
      4'd4: begin t = 9'(m) + 9'(m_d) + 9'(m_df); m_d = t[7:0]; m_df = t[8]; end
      4'd5: begin m_df = (m >= m_d); m_d = m - m_d; end
      4'd6: begin t = 9'(m_d) + 9'(!m_df); m_df = (9'(m) >= t); m_d = m - t[7:0]; end
      4'd7: begin m_df = (m_d >= m); m_d = m_d - m; end
      4'd8: begin t = 9'(m) + 9'(!m_df); m_df = (9'(m_d) >= t); m_d = m_d - t[7:0]; end
      4'd9:  begin m_df = m_d[0]; m_d = {1'b0, m_d[7:1]}; end
      4'd10: begin t[0] = m_df; m_df = m_d[0]; m_d = {t[0], m_d[7:1]}; end
      4'd11: begin m_df = m_d[7]; m_d = {m_d[6:0], 1'b0}; end
      4'd12: begin t[0] = m_df; m_df = m_d[7]; m_d = {m_d[6:0], t[0]}; end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [7:0] ed, input logic edf);
    tests++;
    if (acc_q !== ed || carry_q !== edf || acc_zero !== (ed == 8'd0)) begin
      fails++;
      $display("FAIL %s: acc=%h df=%b z=%b expected acc=%h df=%b z=%b",
               req, acc_q, carry_q, acc_zero, ed, edf, ed == 8'd0);
    end
  endtask

  task automatic do_op(input string req, input logic [3:0] op, input logic [7:0] m,
                       input logic en = 1'b1);
    @(negedge clk);
    op_sel = op; operand = m; wr_en = en;
    if (en) model(op, m);
    @(negedge clk);
    wr_en = 1'b0;
    check(req, m_d, m_df);
  endtask

  task automatic set_state(input logic [7:0] d, input logic df);
    do_op("setup", 4'd1, 8'h00);
    do_op("setup", 4'd0, df ? 8'h01 : 8'h00);
    do_op("setup", 4'd9, 8'h00);
    do_op("setup", 4'd0, d);
  endtask

  task automatic t_reset;
    check("R1", 8'h00, 1'b0);
  endtask

  task automatic t_logic;
    set_state(8'hA5, 1'b1);
    do_op("R2", 4'd0, 8'h0F);
    do_op("R2", 4'd1, 8'h3C);
    do_op("R2", 4'd2, 8'hFF);
    set_state(8'h5A, 1'b0);
    do_op("R2", 4'd2, 8'h5A);
    do_op("R10", 4'd0, 8'h00);
  endtask

  task automatic t_add;
    set_state(8'hFF, 1'b0);
    do_op("R3", 4'd3, 8'h01);
    do_op("R4", 4'd4, 8'h00);
    set_state(8'h7F, 1'b1);
    do_op("R4", 4'd4, 8'h80);
    do_op("R3", 4'd3, 8'h10);
  endtask

  task automatic t_sub;
    set_state(8'h10, 1'b0);
    do_op("R5", 4'd5, 8'h30);
    do_op("R5", 4'd5, 8'h00);
    set_state(8'h05, 1'b1);
    do_op("R5", 4'd7, 8'h05);
    do_op("R5", 4'd7, 8'h01);
    set_state(8'h05, 1'b0);
    do_op("R6", 4'd6, 8'h05);
    set_state(8'h05, 1'b1);
    do_op("R6", 4'd6, 8'h05);
    set_state(8'h05, 1'b0);
    do_op("R6", 4'd8, 8'h04);
    set_state(8'h05, 1'b0);
    do_op("R6", 4'd8, 8'h05);
  endtask

  task automatic t_shift;
    set_state(8'h81, 1'b1);
    do_op("R7", 4'd9, 8'h00);
    set_state(8'h02, 1'b1);
    do_op("R8", 4'd10, 8'h00);
    do_op("R8", 4'd10, 8'h00);
    set_state(8'h81, 1'b0);
    do_op("R9", 4'd11, 8'h00);
    do_op("R9", 4'd12, 8'h00);
    do_op("R9", 4'd12, 8'h00);
  endtask

  task automatic t_idle;
    set_state(8'h3C, 1'b1);
    do_op("R11", 4'd3, 8'hFF, 1'b0);
    do_op("R11", 4'd13, 8'h11);
    do_op("R11", 4'd15, 8'h00);
    set_state(8'h3C, 1'b0);
    do_op("R11", 4'd14, 8'hFF);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 12));
      do_op("R12", op, 8'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: acc=%h df=%b expected run to finish", acc_q, carry_q);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_logic;
    t_add;
    t_sub;
    t_shift;
    t_idle;
    t_random;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule